// File: doc/BRIEF.md
# Performance Monitor Counter Control Unit

This block holds a configurable number of 32-bit event counters and one 64-bit cycle counter. It also holds the control state that decides when each of them runs. Each event counter has its own input pin, which carries single-cycle pulses. The cycle counter advances on every clock edge while it is allowed to run. A counter runs only when two conditions hold together: the global enable in the control word is set, and that counter's own bit in the enable mask is set. The cycle counter's mask bit sits one position above the last event counter.

Software reaches the block through a single-cycle write port and a combinational read port that share one address bus. Through these ports it can:
- turn counting on and off;
- clear the event-counter group or the cycle counter on its own, using write-one strobe bits;
- set or clear individual mask bits without a read-modify-write;
- preload any counter;
- collect wrap events from the sticky overflow bits.

A mode bit selects where the cycle counter reports overflow. It can report at the 32-bit boundary or only when the full 64 bits wrap.

Address map (6-bit address): 0 control, 1 mask set, 2 mask clear, 3 overflow status, 4 cycle counter low word, 5 cycle counter high word, 32+i event counter i. Any unmapped address reads zero. `NUM_EVT` may range from 1 to 31.

Top module: `perf_ctr_unit`

## Requirements
- R1: After reset, every counter, the enable mask and the overflow status read zero. The control word reads only its read-only count field: `NUM_EVT` in bits [15:11], which is 0x2000 for the default of 4.
- R2: While control bit 0 (global enable) is 1 and mask bit i is 1, each pulse on `evt_pulse[i]` adds one to event counter i. When mask bit i is 0, pulses leave counter i unchanged.
- R3: While control bit 0 is 0, no counter changes on events or clocks, whatever the mask holds.
- R4: While control bit 0 is 1 and mask bit `NUM_EVT` is 1, the cycle counter grows by exactly one per clock. While that mask bit is 0, the cycle counter holds.
- R5: A control write with bit 1 set clears all event counters in that write cycle. It leaves the cycle counter unchanged. Bit 1 always reads back as 0.
- R6: A control write with bit 2 set clears only the 64-bit cycle counter. The event counters keep their values. Bit 2 always reads back as 0.
- R7: A control write stores only bit 0 (enable) and bit 3 (long cycle). The read-only field in bits [15:11] keeps its value whatever is written.
- R8: Writing 1s to address 1 sets those mask bits, and writing 1s to address 2 clears them. Writing 0 to either address changes nothing. Both addresses read the current mask, which is `NUM_EVT+1` bits wide; bits above that width are ignored.
- R9: When an event counter wraps from 0xFFFFFFFF to 0, its overflow bit i (address 3) is set and stays set. Writing 1 to a status bit clears it, and writing 0 leaves it.
- R10: With control bit 3 at 0, overflow bit `NUM_EVT` is set when the cycle counter's low 32 bits wrap, and the count carries on into the high word. With bit 3 at 1, that bit is set only when all 64 bits wrap.
- R11: When a reset strobe hits a counter in the same cycle as an increment, the counter ends at zero.
- R12: A write to a counter address loads that counter, or that word of the cycle counter, and takes priority over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | 6 | Register address for both write and read |
| wdata | input | 32 | Write data |
| evt_pulse | input | NUM_EVT | One single-cycle event pulse per event counter |
| rdata | output | 32 | Read data for `addr`, combinational |

## Verification
The hardest conditions to create from the ports are the wrap of a 32-bit event counter and the wrap of the 64-bit cycle counter. Counting up to them is out of reach. The stimulus therefore preloads each counter just below its boundary while counting is stopped, then enables it for a short run. Collisions are the other hard case: a clear strobe or a load arriving on the same edge as an increment. The bench drives the write and the event pulse in the same cycle, and it reads the cycle counter on the very next cycle to catch which one won.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 32;
  localparam int CYC_W   = 64;

  localparam logic [ADDR_W-1:0] A_CTRL  = 6'd0;
  localparam logic [ADDR_W-1:0] A_ENSET = 6'd1;
  localparam logic [ADDR_W-1:0] A_ENCLR = 6'd2;
  localparam logic [ADDR_W-1:0] A_OVF   = 6'd3;
  localparam logic [ADDR_W-1:0] A_CYCLO = 6'd4;
  localparam logic [ADDR_W-1:0] A_CYCHI = 6'd5;
  localparam int                EVT_BASE = 32;

  // control word bit positions
  localparam int B_EN     = 0;
  localparam int B_EVTRST = 1;
  localparam int B_CYCRST = 2;
  localparam int B_LONG   = 3;
  localparam int B_NLO    = 11;
  localparam int B_NHI    = 15;
endpackage

// File: rtl/pmc_regs.sv
module pmc_regs
  import pmc_pkg::*;
#(
  parameter int NUM_EVT = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [NUM_EVT-1:0]  evt_wrap,
  input  logic                cyc_wrap,
  output logic                glb_en,
  output logic                long_mode,
  output logic [NUM_EVT:0]    cnt_mask,
  output logic [NUM_EVT:0]    ovf_flags,
  output logic                evt_clr,
  output logic                cyc_clr,
  output logic [DATA_W-1:0]   ctrl_rd
);
  localparam int MASK_W = NUM_EVT + 1;

  logic ctrl_wr, set_wr, clr_wr, ovf_wr;
  logic en_q, en_d, long_q, long_d;
  logic [MASK_W-1:0] mask_q, mask_d, ovf_q, ovf_d;
  logic mask_ce, ovf_ce;

  always_comb begin
    ctrl_wr = wr_en && (addr == A_CTRL);
    set_wr  = wr_en && (addr == A_ENSET);
    clr_wr  = wr_en && (addr == A_ENCLR);
    ovf_wr  = wr_en && (addr == A_OVF);

    en_d   = wdata[B_EN];
    long_d = wdata[B_LONG];

    mask_d = mask_q;
    if (set_wr) mask_d = mask_d | wdata[MASK_W-1:0];
    if (clr_wr) mask_d = mask_d & ~wdata[MASK_W-1:0];
    mask_ce = set_wr || clr_wr;

    ovf_d = ovf_q;
    if (ovf_wr) ovf_d = ovf_d & ~wdata[MASK_W-1:0];
    ovf_d  = ovf_d | {cyc_wrap, evt_wrap};
    ovf_ce = ovf_wr || cyc_wrap || (|evt_wrap);

    evt_clr = ctrl_wr && wdata[B_EVTRST];
    cyc_clr = ctrl_wr && wdata[B_CYCRST];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      long_q <= 1'b0;
    end else if (ctrl_wr) begin
      en_q   <= en_d;
      long_q <= long_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_ce) mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ovf_q <= '0;
    else if (ovf_ce) ovf_q <= ovf_d;
  end

  always_comb begin
    ctrl_rd                 = '0;
    ctrl_rd[B_EN]           = en_q;
    ctrl_rd[B_LONG]         = long_q;
    ctrl_rd[B_NHI:B_NLO]    = 5'(NUM_EVT);
  end

  assign glb_en    = en_q;
  assign long_mode = long_q;
  assign cnt_mask  = mask_q;
  assign ovf_flags = ovf_q;

  // R8
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_wr && !clr_wr) |=> ((mask_q & $past(wdata[MASK_W-1:0])) == $past(wdata[MASK_W-1:0])));

  // R8
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !set_wr) |=> ((mask_q & $past(wdata[MASK_W-1:0])) == '0));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_wr |=> (($past(ovf_q) & ~ovf_q) == '0));
endmodule

// File: rtl/pmc_evt_ctr.sv
module pmc_evt_ctr #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_data,
  output logic [CNT_W-1:0] value,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_ce = clr || ld || inc;
    if (clr)      cnt_d = '0;
    else if (ld)  cnt_d = ld_data;
    else if (inc) cnt_d = cnt_q + 1'b1;
    wrap = inc && !clr && !ld && (&cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign value = cnt_q;

  // R5
  evt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (value == '0));

  // R2
  evt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && !ld) |=> (value == $past(value) + 1'b1));

  // R12
  evt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !clr) |=> (value == $past(ld_data)));
endmodule

// File: rtl/pmc_cyc_ctr.sv
module pmc_cyc_ctr
  import pmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              clr,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              long_mode,
  output logic [CYC_W-1:0]  value,
  output logic              wrap
);
  logic [CYC_W-1:0] cyc_q, cyc_d;
  logic             cyc_ce, step;

  always_comb begin
    step   = run && !clr && !ld_lo && !ld_hi;
    cyc_ce = clr || ld_lo || ld_hi || run;
    cyc_d  = cyc_q;
    if (clr)        cyc_d = '0;
    else if (ld_lo) cyc_d = {cyc_q[CYC_W-1:DATA_W], ld_data};
    else if (ld_hi) cyc_d = {ld_data, cyc_q[DATA_W-1:0]};
    else if (run)   cyc_d = cyc_q + 1'b1;
    wrap = step && (long_mode ? (&cyc_q) : (&cyc_q[DATA_W-1:0]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cyc_q <= '0;
    else if (cyc_ce) cyc_q <= cyc_d;
  end

  assign value = cyc_q;

  // R4
  cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (value == $past(value) + 1'b1));

  // R6
  cyc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (value == '0));

  // R10
  cyc_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && long_mode && !(&value)) |-> !wrap);
endmodule

// File: rtl/perf_ctr_unit.sv
module perf_ctr_unit
  import pmc_pkg::*;
#(
  parameter int NUM_EVT = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [NUM_EVT-1:0]  evt_pulse,
  output logic [DATA_W-1:0]   rdata
);
  localparam int MASK_W = NUM_EVT + 1;
  localparam int CYC_IX = NUM_EVT;

  logic              glb_en, long_mode, evt_clr, cyc_clr;
  logic [MASK_W-1:0] cnt_mask, ovf_flags, run_vec;
  logic [DATA_W-1:0] ctrl_rd;
  logic [NUM_EVT-1:0] evt_wrap;
  logic              cyc_wrap;
  logic [CYC_W-1:0]  cyc_val;
  logic [DATA_W-1:0] evt_val [NUM_EVT];

  pmc_regs #(.NUM_EVT(NUM_EVT)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .evt_wrap  (evt_wrap),
    .cyc_wrap  (cyc_wrap),
    .glb_en    (glb_en),
    .long_mode (long_mode),
    .cnt_mask  (cnt_mask),
    .ovf_flags (ovf_flags),
    .evt_clr   (evt_clr),
    .cyc_clr   (cyc_clr),
    .ctrl_rd   (ctrl_rd)
  );

  assign run_vec = cnt_mask & {MASK_W{glb_en}};

  for (genvar gi = 0; gi < NUM_EVT; gi++) begin : g_evt
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(EVT_BASE + gi);
    logic ld_i;
    assign ld_i = wr_en && (addr == MY_ADDR);
    pmc_evt_ctr #(.CNT_W(DATA_W)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (run_vec[gi] && evt_pulse[gi]),
      .clr     (evt_clr),
      .ld      (ld_i),
      .ld_data (wdata),
      .value   (evt_val[gi]),
      .wrap    (evt_wrap[gi])
    );
  end

  pmc_cyc_ctr u_cyc (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_vec[CYC_IX]),
    .clr       (cyc_clr),
    .ld_lo     (wr_en && (addr == A_CYCLO)),
    .ld_hi     (wr_en && (addr == A_CYCHI)),
    .ld_data   (wdata),
    .long_mode (long_mode),
    .value     (cyc_val),
    .wrap      (cyc_wrap)
  );

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_CTRL:          rdata = ctrl_rd;
      A_ENSET, A_ENCLR: rdata = DATA_W'(cnt_mask);
      A_OVF:           rdata = DATA_W'(ovf_flags);
      A_CYCLO:         rdata = cyc_val[DATA_W-1:0];
      A_CYCHI:         rdata = cyc_val[CYC_W-1:DATA_W];
      default: begin
        for (int i = 0; i < NUM_EVT; i++)
          if (addr == ADDR_W'(EVT_BASE + i)) rdata = evt_val[i];
      end
    endcase
  end

  // R3
  gbl_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en && !wr_en) |=> ($stable(cyc_val) && $stable(ovf_flags)));

  // R6
  cyc_rst_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_clr && !evt_clr && !(|(run_vec[NUM_EVT-1:0] & evt_pulse))) |=> $stable(evt_val[0]));

  // R5
  evt_rst_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_clr && !cyc_clr && !run_vec[CYC_IX]) |=> $stable(cyc_val));
endmodule

// File: tb/perf_ctr_unit_test.sv
`timescale 1ns/1ps
module perf_ctr_unit_test;
  localparam int NE = 4;
  localparam logic [31:0] CYCB = 32'h1 << NE;
  localparam logic [31:0] ALLM = (32'h1 << (NE + 1)) - 1;
  localparam logic [5:0] A_CTRL = 6'd0, A_SET = 6'd1, A_CLR = 6'd2, A_OVF = 6'd3,
                         A_CLO = 6'd4, A_CHI = 6'd5, A_E0 = 6'd32;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en;
  logic [5:0] addr;
  logic [31:0] wdata;
  logic [NE-1:0] evt_pulse;
  logic [31:0] rdata;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  perf_ctr_unit #(.NUM_EVT(NE)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .evt_pulse(evt_pulse), .rdata(rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_evt(input logic [5:0] a, input logic [31:0] d, input logic [NE-1:0] p);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; evt_pulse = p;
    @(negedge clk);
    wr_en = 1'b0; evt_pulse = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic pulse(input logic [NE-1:0] p);
    @(negedge clk);
    evt_pulse = p;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic test_reset();
    logic [31:0] v;
    rd(A_CTRL, v); chk("R1 ctrl", v, 32'h2000);
    rd(A_SET, v);  chk("R1 mask", v, 0);
    rd(A_OVF, v);  chk("R1 ovf", v, 0);
    rd(A_CLO, v);  chk("R1 cyc lo", v, 0);
    rd(A_E0, v);   chk("R1 evt0", v, 0);
  endtask

  task automatic test_gating();
    logic [31:0] v;
    wr(A_SET, 32'h1);
    wr(A_CTRL, 32'h1);
    pulse(4'b0011);
    rd(A_E0, v);     chk("R2 evt0 masked on", v, 1);
    rd(A_E0 + 1, v); chk("R2 evt1 masked off", v, 0);
    pulse(4'b0001); pulse(4'b0001);
    rd(A_E0, v);     chk("R2 evt0 three", v, 3);
    rd(A_CLO, v);    chk("R4 cyc held by mask", v, 0);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic test_global_off();
    logic [31:0] v;
    wr(A_SET, ALLM);
    pulse(4'hF); pulse(4'hF);
    rd(A_E0, v);     chk("R3 evt0 frozen", v, 3);
    rd(A_E0 + 2, v); chk("R3 evt2 frozen", v, 0);
    idle(5);
    rd(A_CLO, v);    chk("R3 cyc frozen", v, 0);
  endtask

  task automatic test_cycle();
    logic [31:0] a, b;
    wr(A_CTRL, 32'h1);
    rd(A_CLO, a);
    idle(10);
    rd(A_CLO, b);
    chk("R4 cycle step", b - a, 10);
    pulse(4'hF);
    rd(A_E0, a);     chk("R2 evt0 all", a, 4);
    rd(A_E0 + 3, a); chk("R2 evt3 all", a, 1);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic test_evt_reset();
    logic [31:0] c, v;
    rd(A_CLO, c);
    wr(A_CTRL, 32'h2);
    rd(A_E0, v);     chk("R5 evt0 cleared", v, 0);
    rd(A_E0 + 3, v); chk("R5 evt3 cleared", v, 0);
    rd(A_CLO, v);    chk("R5 cyc untouched", v, c);
    rd(A_CTRL, v);   chk("R5 strobe reads zero", v, 32'h2000);
  endtask

  task automatic test_cyc_reset();
    logic [31:0] v;
    wr(A_E0 + 2, 32'd77);
    wr(A_CHI, 32'd3);
    wr(A_CTRL, 32'h4);
    rd(A_CLO, v);    chk("R6 cyc lo cleared", v, 0);
    rd(A_CHI, v);    chk("R6 cyc hi cleared", v, 0);
    rd(A_E0 + 2, v); chk("R6 evt2 untouched", v, 77);
    rd(A_CTRL, v);   chk("R6 strobe reads zero", v, 32'h2000);
  endtask

  task automatic test_ctrl_ro();
    logic [31:0] v;
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, v);   chk("R7 writable bits only", v, 32'h2009);
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, v);   chk("R7 ro field kept", v, 32'h2000);
    wr(A_CLR, ALLM);
    wr(A_CTRL, 32'h6);
  endtask

  task automatic test_mask();
    logic [31:0] v;
    wr(A_SET, 32'h5);  rd(A_SET, v); chk("R8 set", v, 32'h5);
    wr(A_SET, 32'h0);  rd(A_SET, v); chk("R8 set zero no effect", v, 32'h5);
    wr(A_CLR, 32'h1);  rd(A_CLR, v); chk("R8 clr", v, 32'h4);
    wr(A_CLR, 32'h0);  rd(A_SET, v); chk("R8 clr zero no effect", v, 32'h4);
    wr(A_SET, 32'hFFFF_FFFF); rd(A_SET, v); chk("R8 width", v, ALLM);
    wr(A_CLR, 32'hFFFF_FFFF); rd(A_CLR, v); chk("R8 clr all", v, 0);
  endtask

  task automatic test_evt_ovf();
    logic [31:0] v;
    wr(A_OVF, 32'hFFFF_FFFF);
    wr(A_E0, 32'hFFFF_FFFF);
    wr(A_E0 + 1, 32'hFFFF_FFFE);
    wr(A_SET, 32'h3);
    wr(A_CTRL, 32'h1);
    pulse(4'b0011);
    rd(A_E0, v);     chk("R9 evt0 wrapped", v, 0);
    rd(A_E0 + 1, v); chk("R9 evt1 top", v, 32'hFFFF_FFFF);
    rd(A_OVF, v);    chk("R9 ovf0 set", v, 32'h1);
    wr(A_OVF, 32'h0);
    rd(A_OVF, v);    chk("R9 write zero keeps", v, 32'h1);
    pulse(4'b0010);
    rd(A_OVF, v);    chk("R9 ovf1 set", v, 32'h3);
    wr(A_OVF, 32'h1);
    rd(A_OVF, v);    chk("R9 w1c", v, 32'h2);
    wr(A_CTRL, 32'h0);
    wr(A_CLR, ALLM);
    wr(A_OVF, 32'hFFFF_FFFF);
  endtask

  task automatic test_cyc_ovf();
    logic [31:0] v;
    wr(A_CHI, 32'h0); wr(A_CLO, 32'hFFFF_FFF0);
    wr(A_SET, CYCB);
    wr(A_CTRL, 32'h1);
    idle(30);
    wr(A_CTRL, 32'h0);
    rd(A_OVF, v);  chk("R10 short ovf", v, CYCB);
    rd(A_CHI, v);  chk("R10 carry into hi", v, 1);
    wr(A_OVF, CYCB);
    wr(A_CHI, 32'h0); wr(A_CLO, 32'hFFFF_FFF0);
    wr(A_CTRL, 32'h9);
    idle(30);
    wr(A_CTRL, 32'h8);
    rd(A_OVF, v);  chk("R10 long no ovf at 32", v, 0);
    rd(A_CHI, v);  chk("R12 hi load then carry", v, 1);
    wr(A_CHI, 32'hFFFF_FFFF); wr(A_CLO, 32'hFFFF_FFF0);
    wr(A_CTRL, 32'h9);
    idle(30);
    wr(A_CTRL, 32'h0);
    rd(A_OVF, v);  chk("R10 long ovf at 64", v, CYCB);
    rd(A_CHI, v);  chk("R10 full wrap", v, 0);
    wr(A_OVF, 32'hFFFF_FFFF);
  endtask

  task automatic test_collision();
    logic [31:0] v;
    wr(A_E0, 32'd5);
    wr(A_SET, ALLM);
    wr(A_CTRL, 32'h1);
    wr_evt(A_CTRL, 32'h3, 4'hF);
    rd(A_E0, v);     chk("R11 evt reset beats pulse", v, 0);
    rd(A_E0 + 2, v); chk("R11 evt2 reset beats pulse", v, 0);
    wr(A_CTRL, 32'h5);
    rd(A_CLO, v);    chk("R11 cyc reset beats step", v, 0);
    rd(A_CHI, v);    chk("R11 cyc hi zero", v, 0);
    idle(1);
    rd(A_CLO, v);    chk("R4 cyc resumes", v, 1);
  endtask

  task automatic test_load();
    logic [31:0] v;
    wr_evt(A_E0, 32'd100, 4'h1);
    rd(A_E0, v);     chk("R12 load beats pulse", v, 100);
    pulse(4'h1);
    rd(A_E0, v);     chk("R12 count after load", v, 101);
    wr(A_CTRL, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; evt_pulse = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    test_reset();
    test_gating();
    test_global_off();
    test_cycle();
    test_evt_reset();
    test_cyc_reset();
    test_ctrl_ro();
    test_mask();
    test_evt_ovf();
    test_cyc_ovf();
    test_collision();
    test_load();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule